// File: doc/BRIEF.md
# DSP Data Address Generator

This unit supplies the data-memory addresses for two parallel data buses of an audio signal processor. It keeps eight register sets. Each set holds a pointer, a step (offset) value and a modifier. On each cycle, each bus may name one set and an addressing mode. The unit returns the effective address for that access and, where the mode calls for it, writes the stepped pointer back.

The modifier of a set chooses its arithmetic:
- **Plain linear** stepping.
- **Bit-reversed stepping.** The carry runs from the top bit downward. This gives the shuffled order used by FFT buffers.
- **Circular stepping** within a buffer of programmable length.

The surrounding decoder uses a load port to initialise pointers, steps and modifiers. It uses a read port to take their values back.

Top module: `dsp_agu`

## Requirements
- R1: Reset sets every pointer and every step to 0 and every modifier to 0xFFFF. It also clears both bus address outputs, their valid flags and the read-port outputs.
- R2: A request on a bus (en high) gives its address and a valid flag one clock later. Without a request, the valid flag is low in the next cycle.
- R3: Mode codes on the 3-bit mode inputs:
  - 0: pointer, no update
  - 1: pointer, then pointer+1
  - 2: pointer, then pointer-1
  - 3: pointer, then pointer+step
  - 4: pointer, then pointer-step
  - 5: pointer+step, pointer unchanged
  - 6: pointer-1, which is also written back
  - 7: same as 0

  A pointer that no bus updates and the load port does not write keeps its value.
- R4: A modifier of 0xFFFF, or any modifier from 0x8000 to 0xFFFE, gives linear arithmetic modulo 2^16. For example, 0xFFFF+1 gives 0.
- R5: A modifier m from 1 to 0x7FFF gives a circular buffer of length L=m+1.
  - The buffer base is the pointer with its low k bits cleared, where 2^k is the smallest power of two not below L.
  - Stepping past base+m wraps to the base. Stepping below the base wraps to base+m.
  - Step magnitudes are at most L.
- R6: A modifier of 0 gives bit-reversed arithmetic. The add or subtract propagates its carry or borrow from bit 15 toward bit 0.
- R7: Both buses may access and update in the same cycle. Each bus reads the register values from before that cycle. When both update the same pointer, the X bus result is kept.
- R8: The load port writes the pointer (kind 0), step (kind 1) or modifier (kind 2) of the selected set at the clock edge. Kind 3 writes nothing. A load overrides a same-cycle bus update of that pointer, and the loaded value is used from the next cycle on.
- R9: The read port gives the selected pointer, step or modifier (kinds 0, 1 and 2) one clock after rd_en, with rd_vld high. The value is the one from before any same-cycle update. Kind 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_en | input | 1 | X bus access request |
| x_sel | input | 3 | X bus register set |
| x_mode | input | 3 | X bus addressing mode |
| y_en | input | 1 | Y bus access request |
| y_sel | input | 3 | Y bus register set |
| y_mode | input | 3 | Y bus addressing mode |
| ld_en | input | 1 | Load strobe |
| ld_kind | input | 2 | Load target: 0 pointer, 1 step, 2 modifier, 3 none |
| ld_sel | input | 3 | Load register set |
| ld_data | input | 16 | Load value |
| rd_en | input | 1 | Read strobe |
| rd_kind | input | 2 | Read target: 0 pointer, 1 step, 2 modifier, 3 zero |
| rd_sel | input | 3 | Read register set |
| x_addr | output | 16 | X bus effective address |
| x_vld | output | 1 | X address valid |
| y_addr | output | 16 | Y bus effective address |
| y_vld | output | 1 | Y address valid |
| rd_data | output | 16 | Read value |
| rd_vld | output | 1 | Read value valid |

## Verification
The two functions that share a cycle are the two bus updates. The bench drives the X and Y buses onto the same register set with different updating modes in one cycle. It also pairs a load with a bus increment of the same pointer, and a read with an update of the pointer being read. A scoreboard model predicts the result from the pre-cycle state with the Y bus, then the X bus, then the load applied. A plain access on the following cycle must show the pointer that the stated priority leaves.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    MD_PLAIN   = 3'd0,
    MD_POSTINC = 3'd1,
    MD_POSTDEC = 3'd2,
    MD_POSTADD = 3'd3,
    MD_POSTSUB = 3'd4,
    MD_INDEX   = 3'd5,
    MD_PREDEC  = 3'd6,
    MD_RSVD    = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    K_PTR  = 2'd0,
    K_STEP = 2'd1,
    K_MOD  = 2'd2,
    K_NONE = 2'd3
  } agu_kind_e;

  typedef enum logic [1:0] {
    AR_LIN = 2'd0,
    AR_REV = 2'd1,
    AR_CIRC = 2'd2
  } agu_arith_e;

endpackage

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] r_i,
  input  logic [AW-1:0] n_i,
  input  logic [AW-1:0] m_i,
  input  agu_mode_e     mode_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] nxt_o,
  output logic          upd_o
);

  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW:0]   ONE_W = (AW+1)'(1);

  logic [AW-1:0] span_mask;
  agu_arith_e    arith;

  // smallest all-ones mask covering the modifier
  always_comb begin
    for (int i = 0; i < AW; i++) span_mask[i] = |(m_i >> i);
  end

  always_comb begin
    if (m_i == '0)        arith = AR_REV;
    else if (m_i[AW-1])   arith = AR_LIN;
    else                  arith = AR_CIRC;
  end

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] res;
    for (int i = 0; i < AW; i++) res[i] = v[AW-1-i];
    return res;
  endfunction

  function automatic logic [AW-1:0] step(
    input logic [AW-1:0] a,
    input logic [AW-1:0] mag,
    input logic          sub,
    input logic [AW-1:0] m,
    input logic [AW-1:0] msk,
    input agu_arith_e    k
  );
    logic [AW-1:0] rs;
    logic [AW:0]   off;
    logic [AW:0]   t;
    logic [AW-1:0] res;
    case (k)
      AR_REV: begin
        rs  = sub ? (flip(a) - flip(mag)) : (flip(a) + flip(mag));
        res = flip(rs);
      end
      AR_CIRC: begin
        off = {1'b0, a & msk};
        if (!sub) begin
          t = off + {1'b0, mag};
          if (t > {1'b0, m}) t = t - ({1'b0, m} + ONE_W);
        end else begin
          t = off - {1'b0, mag};
          if (t[AW]) t = t + {1'b0, m} + ONE_W;
        end
        res = (a & ~msk) | (t[AW-1:0] & msk);
      end
      default: res = sub ? (a - mag) : (a + mag);
    endcase
    return res;
  endfunction

  always_comb begin
    ea_o  = r_i;
    nxt_o = r_i;
    upd_o = 1'b0;
    case (mode_i)
      MD_POSTINC: begin
        nxt_o = step(r_i, ONE, 1'b0, m_i, span_mask, arith);
        upd_o = 1'b1;
      end
      MD_POSTDEC: begin
        nxt_o = step(r_i, ONE, 1'b1, m_i, span_mask, arith);
        upd_o = 1'b1;
      end
      MD_POSTADD: begin
        nxt_o = step(r_i, n_i, 1'b0, m_i, span_mask, arith);
        upd_o = 1'b1;
      end
      MD_POSTSUB: begin
        nxt_o = step(r_i, n_i, 1'b1, m_i, span_mask, arith);
        upd_o = 1'b1;
      end
      MD_INDEX: begin
        ea_o = step(r_i, n_i, 1'b0, m_i, span_mask, arith);
      end
      MD_PREDEC: begin
        nxt_o = step(r_i, ONE, 1'b1, m_i, span_mask, arith);
        ea_o  = nxt_o;
        upd_o = 1'b1;
      end
      default: ;
    endcase
  end

  // circular increment from inside the buffer must stay inside it
  always_comb begin
    if (arith == AR_CIRC && mode_i == MD_POSTINC && (r_i & span_mask) <= m_i) begin
      assert_mod_in_buffer_R5: assert (((nxt_o & ~span_mask) == (r_i & ~span_mask)) &&
                                       ((nxt_o & span_mask) <= m_i));
    end
  end

endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 16,
  parameter int NB   = 2,
  localparam int SW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NB-1:0][SW-1:0]  acc_sel,
  output logic [NB-1:0][AW-1:0]  acc_r,
  output logic [NB-1:0][AW-1:0]  acc_n,
  output logic [NB-1:0][AW-1:0]  acc_m,
  input  logic [NB-1:0]          up_en,
  input  logic [NB-1:0][SW-1:0]  up_sel,
  input  logic [NB-1:0][AW-1:0]  up_val,
  input  logic                   ld_en,
  input  agu_kind_e              ld_kind,
  input  logic [SW-1:0]          ld_sel,
  input  logic [AW-1:0]          ld_data,
  input  logic                   rd_en,
  input  agu_kind_e              rd_kind,
  input  logic [SW-1:0]          rd_sel,
  output logic [AW-1:0]          rd_data
);

  logic [AW-1:0]   r_q [NREG];
  logic [AW-1:0]   n_q [NREG];
  logic [AW-1:0]   m_q [NREG];
  logic [AW-1:0]   r_d [NREG];
  logic [AW-1:0]   n_d [NREG];
  logic [AW-1:0]   m_d [NREG];
  logic [NREG-1:0] r_we;

  for (genvar b = 0; b < NB; b++) begin : g_port
    assign acc_r[b] = r_q[acc_sel[b]];
    assign acc_n[b] = n_q[acc_sel[b]];
    assign acc_m[b] = m_q[acc_sel[b]];
  end

  // priority: load, then lowest bus index
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      r_d[i]  = r_q[i];
      n_d[i]  = n_q[i];
      m_d[i]  = m_q[i];
      r_we[i] = 1'b0;
      for (int b = NB-1; b >= 0; b--) begin
        if (up_en[b] && up_sel[b] == SW'(i)) begin
          r_d[i]  = up_val[b];
          r_we[i] = 1'b1;
        end
      end
      if (ld_en && ld_sel == SW'(i)) begin
        case (ld_kind)
          K_PTR: begin
            r_d[i]  = ld_data;
            r_we[i] = 1'b1;
          end
          K_STEP:  n_d[i] = ld_data;
          K_MOD:   m_d[i] = ld_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        r_q[i] <= '0;
        n_q[i] <= '0;
        m_q[i] <= '1;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        r_q[i] <= r_d[i];
        n_q[i] <= n_d[i];
        m_q[i] <= m_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_kind)
        K_PTR:   rd_data <= r_q[rd_sel];
        K_STEP:  rd_data <= n_q[rd_sel];
        K_MOD:   rd_data <= m_q[rd_sel];
        default: rd_data <= '0;
      endcase
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_hold
    assert_r_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !r_we[i] |=> $stable(r_q[i]));
  end

  assert_bus0_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (up_en[0] && up_en[NB-1] && up_sel[0] == up_sel[NB-1] &&
     !(ld_en && ld_kind == K_PTR && ld_sel == up_sel[0]))
    |=> r_q[$past(up_sel[0])] == $past(up_val[0]));

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 16,
  localparam int SW  = $clog2(NREG),
  localparam int NB  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x_en,
  input  logic [SW-1:0] x_sel,
  input  logic [2:0]    x_mode,
  input  logic          y_en,
  input  logic [SW-1:0] y_sel,
  input  logic [2:0]    y_mode,
  input  logic          ld_en,
  input  logic [1:0]    ld_kind,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_kind,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] x_addr,
  output logic          x_vld,
  output logic [AW-1:0] y_addr,
  output logic          y_vld,
  output logic [AW-1:0] rd_data,
  output logic          rd_vld
);

  logic [NB-1:0]         req_en;
  logic [NB-1:0][SW-1:0] req_sel;
  agu_mode_e             req_mode [NB];
  logic [NB-1:0][AW-1:0] acc_r, acc_n, acc_m;
  logic [NB-1:0][AW-1:0] ea, nxt;
  logic [NB-1:0]         upd, up_en;
  logic [NB-1:0][AW-1:0] addr_q;
  logic [NB-1:0]         vld_q;
  logic                  rd_vld_q;

  assign req_en      = {y_en, x_en};
  assign req_sel     = {y_sel, x_sel};
  assign req_mode[0] = agu_mode_e'(x_mode);
  assign req_mode[1] = agu_mode_e'(y_mode);

  agu_regfile #(.NREG(NREG), .AW(AW), .NB(NB)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .acc_sel (req_sel),
    .acc_r   (acc_r),
    .acc_n   (acc_n),
    .acc_m   (acc_m),
    .up_en   (up_en),
    .up_sel  (req_sel),
    .up_val  (nxt),
    .ld_en   (ld_en),
    .ld_kind (agu_kind_e'(ld_kind)),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .rd_en   (rd_en),
    .rd_kind (agu_kind_e'(rd_kind)),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bus
    agu_calc #(.AW(AW)) u_calc (
      .r_i    (acc_r[b]),
      .n_i    (acc_n[b]),
      .m_i    (acc_m[b]),
      .mode_i (req_mode[b]),
      .ea_o   (ea[b]),
      .nxt_o  (nxt[b]),
      .upd_o  (upd[b])
    );
    assign up_en[b] = req_en[b] & upd[b];

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[b] <= '0;
        vld_q[b]  <= 1'b0;
      end else begin
        vld_q[b] <= req_en[b];
        if (req_en[b]) addr_q[b] <= ea[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld_q <= 1'b0;
    else     rd_vld_q <= rd_en;
  end

  assign x_addr = addr_q[0];
  assign x_vld  = vld_q[0];
  assign y_addr = addr_q[1];
  assign y_vld  = vld_q[1];
  assign rd_vld = rd_vld_q;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!x_vld && !y_vld && !rd_vld && x_addr == '0 && y_addr == '0 && rd_data == '0));

  assert_x_latency_R2: assert property (@(posedge clk) disable iff (rst)
    x_en |=> x_vld);

  assert_y_latency_R2: assert property (@(posedge clk) disable iff (rst)
    y_en |=> y_vld);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    (!x_en && !y_en) |=> (!x_vld && !y_vld));

  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);

endmodule

// File: tb/tb_dsp_agu.sv
`timescale 1ns/1ps
module tb_dsp_agu;

  localparam int PL = 0, PI = 1, PD = 2, PA = 3, PS = 4, IX = 5, PR = 6, RS = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        x_en = 0, y_en = 0, ld_en = 0, rd_en = 0;
  logic [2:0]  x_sel = 0, x_mode = 0, y_sel = 0, y_mode = 0, ld_sel = 0, rd_sel = 0;
  logic [1:0]  ld_kind = 0, rd_kind = 0;
  logic [15:0] ld_data = 0;
  logic [15:0] x_addr, y_addr, rd_data;
  logic        x_vld, y_vld, rd_vld;

  always #2.5 clk = ~clk;

  dsp_agu dut (
    .clk(clk), .rst(rst),
    .x_en(x_en), .x_sel(x_sel), .x_mode(x_mode),
    .y_en(y_en), .y_sel(y_sel), .y_mode(y_mode),
    .ld_en(ld_en), .ld_kind(ld_kind), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_en(rd_en), .rd_kind(rd_kind), .rd_sel(rd_sel),
    .x_addr(x_addr), .x_vld(x_vld), .y_addr(y_addr), .y_vld(y_vld),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] mr [8];
  logic [15:0] mn [8];
  logic [15:0] mm [8];

  logic [15:0] qx_v[$], qy_v[$], qr_v[$];
  string       qx_t[$], qy_t[$], qr_t[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mstep(input logic [15:0] r, input logic [15:0] mag,
                                        input bit sub, input logic [15:0] m);
    logic [15:0] res;
    if (m == 16'h0000) begin
      logic [15:0] b;
      bit c;
      b = sub ? ~mag : mag;
      c = sub;
      for (int i = 15; i >= 0; i--) begin
        res[i] = r[i] ^ b[i] ^ c;
        c = (r[i] & b[i]) | (c & (r[i] ^ b[i]));
      end
    end else if (m[15]) begin
      res = sub ? r - mag : r + mag;
    end else begin
      int len, p, base, off, t;
      len = int'(m) + 1;
      p = 1;
      while (p < len) p = p * 2;
      off  = int'(r) % p;
      base = int'(r) - off;
      t = sub ? off - int'(mag) : off + int'(mag);
      t = ((t % len) + len) % len;
      res = 16'(base + t);
    end
    return res;
  endfunction

  task automatic model(input int s, input int md, output logic [15:0] ea,
                       output logic [15:0] nx, output bit up);
    ea = mr[s]; nx = mr[s]; up = 0;
    case (md)
      PI: begin nx = mstep(mr[s], 16'd1, 0, mm[s]); up = 1; end
      PD: begin nx = mstep(mr[s], 16'd1, 1, mm[s]); up = 1; end
      PA: begin nx = mstep(mr[s], mn[s], 0, mm[s]); up = 1; end
      PS: begin nx = mstep(mr[s], mn[s], 1, mm[s]); up = 1; end
      IX: ea = mstep(mr[s], mn[s], 0, mm[s]);
      PR: begin nx = mstep(mr[s], 16'd1, 1, mm[s]); ea = nx; up = 1; end
      default: ;
    endcase
  endtask

  task automatic drive(input bit xe, input int xs, input int xm,
                       input bit ye, input int ys, input int ym,
                       input bit le, input int lk, input int ls, input int lv,
                       input bit re, input int rk, input int rs, input string tag);
    logic [15:0] xea, xnx, yea, ynx;
    bit xup, yup;
    @(negedge clk);
    x_en = xe; x_sel = 3'(xs); x_mode = 3'(xm);
    y_en = ye; y_sel = 3'(ys); y_mode = 3'(ym);
    ld_en = le; ld_kind = 2'(lk); ld_sel = 3'(ls); ld_data = 16'(lv);
    rd_en = re; rd_kind = 2'(rk); rd_sel = 3'(rs);
    if (re) begin
      qr_v.push_back(rk == 0 ? mr[rs] : rk == 1 ? mn[rs] : rk == 2 ? mm[rs] : 16'h0);
      qr_t.push_back(tag);
    end
    xup = 0; yup = 0;
    if (xe) begin model(xs, xm, xea, xnx, xup); qx_v.push_back(xea); qx_t.push_back(tag); end
    if (ye) begin model(ys, ym, yea, ynx, yup); qy_v.push_back(yea); qy_t.push_back(tag); end
    if (ye && yup) mr[ys] = ynx;
    if (xe && xup) mr[xs] = xnx;
    if (le) begin
      case (lk)
        0: mr[ls] = 16'(lv);
        1: mn[ls] = 16'(lv);
        2: mm[ls] = 16'(lv);
        default: ;
      endcase
    end
  endtask

  task automatic ax(input int s, input int md, input string t);
    drive(1, s, md, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, t);
  endtask
  task automatic ay(input int s, input int md, input string t);
    drive(0, 0, 0, 1, s, md, 0, 0, 0, 0, 0, 0, 0, t);
  endtask
  task automatic ld(input int k, input int s, input int v, input string t);
    drive(0, 0, 0, 0, 0, 0, 1, k, s, v, 0, 0, 0, t);
  endtask
  task automatic rdr(input int k, input int s, input string t);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, k, s, t);
  endtask
  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (x_vld) begin
        if (qx_v.size() == 0) check("R2 x unexpected", x_addr, 16'hxxxx);
        else check({qx_t.pop_front(), " x_addr"}, x_addr, qx_v.pop_front());
      end
      if (y_vld) begin
        if (qy_v.size() == 0) check("R2 y unexpected", y_addr, 16'hxxxx);
        else check({qy_t.pop_front(), " y_addr"}, y_addr, qy_v.pop_front());
      end
      if (rd_vld) begin
        if (qr_v.size() == 0) check("R9 rd unexpected", rd_data, 16'hxxxx);
        else check({qr_t.pop_front(), " rd_data"}, rd_data, qr_v.pop_front());
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mr[i] = 0; mn[i] = 0; mm[i] = 16'hFFFF; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: outputs quiet after reset, register defaults via read port
    check("R1 x_vld", {15'd0, x_vld}, 16'd0);
    check("R1 y_vld", {15'd0, y_vld}, 16'd0);
    check("R1 rd_vld", {15'd0, rd_vld}, 16'd0);
    check("R1 x_addr", x_addr, 16'd0);
    rdr(2, 0, "R1 mod0");
    rdr(2, 7, "R1 mod7");
    rdr(0, 5, "R1 ptr5");
    rdr(1, 3, "R1 step3");

    // R3 and R4: every mode on linear arithmetic
    ld(0, 0, 16'h0100, "R8");
    ld(1, 0, 16'h0004, "R8");
    ax(0, PL, "R3 plain");
    ax(0, PI, "R3 postinc");
    ax(0, PI, "R3 postinc");
    ax(0, PD, "R3 postdec");
    ax(0, PA, "R3 postadd");
    ax(0, PS, "R3 postsub");
    ax(0, IX, "R3 index");
    ax(0, PL, "R3 index no update");
    ax(0, PR, "R3 predec");
    ax(0, RS, "R3 reserved");
    ay(0, PI, "R3 y postinc");
    ay(0, PL, "R3 y plain");

    // R4: wrap at 16 bits, upper modifier range is linear
    ld(0, 1, 16'hFFFF, "R4");
    ax(1, PI, "R4 wrap");
    ax(1, PL, "R4 wrapped");
    ax(1, PD, "R4 underflow");
    ld(2, 1, 16'h9000, "R4");
    ld(0, 1, 16'h0010, "R4");
    ld(1, 1, 16'h0020, "R4");
    ax(1, PA, "R4 m9000 add");
    ax(1, PA, "R4 m9000 add");
    ax(1, PL, "R4 m9000 result");

    // R5: circular buffers
    ld(2, 2, 9, "R5");
    ld(0, 2, 16'h0020, "R5");
    ld(1, 2, 3, "R5");
    for (int i = 0; i < 12; i++) ax(2, PI, "R5 inc wrap");
    for (int i = 0; i < 4; i++) ax(2, PD, "R5 dec wrap");
    for (int i = 0; i < 5; i++) ax(2, PA, "R5 add wrap");
    for (int i = 0; i < 5; i++) ax(2, PS, "R5 sub wrap");
    ax(2, IX, "R5 index");
    ax(2, PR, "R5 predec");
    ax(2, PL, "R5 final");
    ld(2, 3, 7, "R5");
    ld(0, 3, 16'h0045, "R5");
    ld(1, 3, 5, "R5");
    for (int i = 0; i < 5; i++) ax(3, PA, "R5 pow2 add");
    ld(2, 7, 16'h7FFF, "R5");
    ld(0, 7, 16'h8000, "R5");
    ax(7, PD, "R5 32768 dec");
    ax(7, PL, "R5 32768 top");
    ax(7, PI, "R5 32768 inc");
    ax(7, PL, "R5 32768 base");

    // R6: bit-reversed stepping
    ld(2, 4, 0, "R6");
    ld(0, 4, 0, "R6");
    ld(1, 4, 8, "R6");
    for (int i = 0; i < 17; i++) ax(4, PA, "R6 rev add");
    for (int i = 0; i < 4; i++) ax(4, PS, "R6 rev sub");
    for (int i = 0; i < 3; i++) ax(4, PI, "R6 rev inc");
    ax(4, PD, "R6 rev dec");
    ax(4, PL, "R6 final");

    // R7: dual bus in one cycle
    ld(0, 5, 16'h0200, "R7");
    ld(0, 6, 16'h0300, "R7");
    drive(1, 5, PI, 1, 6, PD, 0, 0, 0, 0, 0, 0, 0, "R7 distinct sets");
    drive(1, 5, PL, 1, 6, PL, 0, 0, 0, 0, 0, 0, 0, "R7 distinct result");
    drive(1, 5, PI, 1, 5, PD, 0, 0, 0, 0, 0, 0, 0, "R7 same set x wins");
    ax(5, PL, "R7 x kept");
    drive(1, 5, IX, 1, 5, PI, 0, 0, 0, 0, 0, 0, 0, "R7 index plus y inc");
    ax(5, PL, "R7 y applied");

    // R8: load collisions and the ignored kind
    drive(1, 5, PI, 0, 0, 0, 1, 0, 5, 16'h0777, 0, 0, 0, "R8 load beats inc");
    ax(5, PL, "R8 loaded");
    drive(0, 0, 0, 0, 0, 0, 1, 3, 6, 16'hBEEF, 0, 0, 0, "R8 kind3");
    rdr(0, 6, "R8 kind3 ptr");
    rdr(1, 6, "R8 kind3 step");
    rdr(2, 6, "R8 kind3 mod");
    drive(1, 6, PI, 0, 0, 0, 1, 2, 6, 3, 0, 0, 0, "R8 old mod this cycle");
    ax(6, PI, "R8 new mod next cycle");

    // R9: read during update, reserved read kind
    drive(1, 5, PI, 0, 0, 0, 0, 0, 0, 0, 1, 0, 5, "R9 pre-update read");
    rdr(0, 5, "R9 post-update read");
    rdr(3, 5, "R9 kind3 zero");
    rdr(1, 2, "R9 step read");

    idle(); idle(); idle();
    check("R2 x queue drained", 16'(qx_v.size()), 16'd0);
    check("R2 y queue drained", 16'(qy_v.size()), 16'd0);
    check("R9 rd queue drained", 16'(qr_v.size()), 16'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule